// File: doc/BRIEF.md
# Audio Link Global Control Unit

This block holds the global control, global status and codec access arbitration state of an audio codec link controller. Software reaches it through a simple register port with an 8-bit offset, a write strobe and a read strobe. Three offsets are decoded: 0x2C for the control word, 0x30 for the status word and 0x34 for the codec access semaphore. Read data is combinational from the offset.

The control word drives the link side outputs directly. These are the cold reset line (active low), a self-timed warm reset pulse, link shut-off, the channel-count selection and the sample-width selection. It also holds the interrupt enables for the resume flags of the three serial data inputs and for the GPI status change. The status word combines three kinds of bit. Some are read-only reflections of codec-ready lines, channel interrupt lines and power-down semaphores. Some are sticky event flags that software clears by writing 1. The last two are capability constants.

The semaphore bit arbitrates accesses to the codec mixer registers. A read at 0x34 returns the bit and claims it in the same access. Only the external codec-access-done pulse releases it. A single interrupt output summarises all pending causes.

Top module: `alink_glb_ctrl`

## Requirements
- R1: After reset the control word reads 0, cold_rst_no is 0 (cold reset active), warm_rst_o is 0, every write-1-to-clear status flag is 0 and the semaphore bit reads 0.
- R2: A write at 0x2C stores bit 0 (GPI interrupt enable), bit 1 (cold reset release, cold_rst_no follows it), bit 3 (link shut-off, drives link_off_o) and bits 6:4 (resume interrupt enables for inputs 2:0), and they read back at 0x2C.
- R3: Control bits 21:20 select 2 (0), 4 (1) or 6 (2) channels and drive chan_sel_o; a write carrying the reserved value 3 in that field leaves the field unchanged.
- R4: Control bit 22 selects 20-bit samples (1) or 16-bit samples (0) and drives wide_smp_o; bit 23 is not stored and reads 0.
- R5: Writing 1 to control bit 2 while bit 1 is already 1 raises warm_rst_o and bit 2 for exactly WARM_CYCLES clock cycles, after which both clear by themselves; bit 2 cannot be written to 0 by software.
- R6: A warm reset request is ignored while cold reset is active (stored bit 1 is 0), and a write that sets bit 1 to 0 ends a running warm reset at once.
- R7: Status bits 8, 9 and 28 show codec_ready_i[0], [1] and [2]. Bits 7, 6, 5, 2 and 1 show chan_irq_i[4] (mic in), [3] (PCM out), [2] (PCM in), [1] (modem out) and [0] (modem in). Bits 16 and 17 show audio_pd_i and modem_pd_i. Bits 20 and 21 are the 4- and 6-channel capability parameters. Writes do not change any of these bits.
- R8: Status bits 10, 11 and 29 are set by a resume_evt_i[0], [1] or [2] pulse and cleared by writing 1 to them. Writing 0 has no effect, and a set arriving in the same cycle as a clear wins.
- R9: Status bit 15 is set by rd_done_i and bit 0 by gpi_evt_i; each is cleared by writing 1 to it.
- R10: A read at 0x34 returns the semaphore in bit 0 and leaves it at 1. Writes at 0x34 have no effect, and only an access_done_i pulse returns it to 0.
- R11: irq_o is high when any chan_irq_i bit is high, when a resume flag is set with its enable (control bits 6:4) set, or when the GPI flag is set with control bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (claims the semaphore at 0x34) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| codec_ready_i | input | 3 | Codec ready per serial data input |
| resume_evt_i | input | 3 | Resume event pulses per serial data input |
| chan_irq_i | input | 5 | Channel interrupts: mic in, PCM out, PCM in, modem out, modem in (4..0) |
| gpi_evt_i | input | 1 | GPI status change pulse |
| rd_done_i | input | 1 | Codec read completion pulse |
| access_done_i | input | 1 | Codec access finished, releases the semaphore |
| audio_pd_i | input | 1 | Audio power-down semaphore |
| modem_pd_i | input | 1 | Modem power-down semaphore |
| cold_rst_no | output | 1 | Cold reset to the link, active low |
| warm_rst_o | output | 1 | Warm reset pulse to the link |
| link_off_o | output | 1 | Link shut-off |
| chan_sel_o | output | 2 | Channel-count selection |
| wide_smp_o | output | 1 | 20-bit sample selection |
| irq_o | output | 1 | Summary interrupt |

## Verification
The assertions assume WARM_CYCLES is at least 1. They also assume the register port never writes and reads in the same cycle, so that a semaphore claim is not mixed with a write at the same offset. The stimulus keeps both strobes one-hot. It drives every event input as a single-cycle pulse, away from the clock edge. It also keeps the level inputs stable across each status read, so the read-only bits can be compared against values the bench predicts itself.

// File: rtl/alink_pkg.sv
package alink_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] CTRL_OFF = 8'h2C;
  localparam logic [ADDR_W-1:0] STA_OFF  = 8'h30;
  localparam logic [ADDR_W-1:0] SEM_OFF  = 8'h34;
  localparam int unsigned N_SDIN = 3;
  localparam int unsigned N_CHIRQ = 5;
  localparam logic [1:0] CHAN_RSVD = 2'd3;
endpackage

// File: rtl/alink_ctrl_reg.sv
module alink_ctrl_reg
  import alink_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              cold_rel_o,
  output logic              warm_o,
  output logic              link_off_o,
  output logic [1:0]        chan_o,
  output logic              wide_o,
  output logic              gpi_ie_o,
  output logic [N_SDIN-1:0] res_ie_o
);
  localparam int unsigned CNT_W = $clog2(WARM_CYCLES + 1);

  logic              gpi_ie_q, cold_rel_q, link_off_q, wide_q, warm_q;
  logic [N_SDIN-1:0] res_ie_q;
  logic [1:0]        chan_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              unused_wd;

  assign unused_wd = ^{wdata_i[31:23], wdata_i[19:7]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpi_ie_q   <= 1'b0;
      cold_rel_q <= 1'b0;
      link_off_q <= 1'b0;
      res_ie_q   <= '0;
      chan_q     <= '0;
      wide_q     <= 1'b0;
    end else if (wr_i) begin
      gpi_ie_q   <= wdata_i[0];
      cold_rel_q <= wdata_i[1];
      link_off_q <= wdata_i[3];
      res_ie_q   <= wdata_i[6:4];
      wide_q     <= wdata_i[22];
      if (wdata_i[21:20] != CHAN_RSVD) chan_q <= wdata_i[21:20];
    end
  end

  // warm reset timer; cold reset (old or newly written) overrides
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_i && !wdata_i[1]) begin
      warm_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_i && wdata_i[2] && cold_rel_q && !warm_q) begin
      warm_q <= 1'b1;
      cnt_q  <= CNT_W'(WARM_CYCLES);
    end else if (warm_q) begin
      if (cnt_q == CNT_W'(1)) begin
        warm_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_comb begin
    ctrl_o        = '0;
    ctrl_o[0]     = gpi_ie_q;
    ctrl_o[1]     = cold_rel_q;
    ctrl_o[2]     = warm_q;
    ctrl_o[3]     = link_off_q;
    ctrl_o[6:4]   = res_ie_q;
    ctrl_o[21:20] = chan_q;
    ctrl_o[22]    = wide_q;
  end

  assign cold_rel_o = cold_rel_q;
  assign warm_o     = warm_q;
  assign link_off_o = link_off_q;
  assign chan_o     = chan_q;
  assign wide_o     = wide_q;
  assign gpi_ie_o   = gpi_ie_q;
  assign res_ie_o   = res_ie_q;
endmodule

// File: rtl/alink_sta_reg.sv
module alink_sta_reg
  import alink_pkg::*;
#(
  parameter bit CAP_4CH = 1'b1,
  parameter bit CAP_6CH = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_SDIN-1:0]  ready_i,
  input  logic [N_SDIN-1:0]  resume_i,
  input  logic [N_CHIRQ-1:0] chirq_i,
  input  logic               gpi_i,
  input  logic               rdone_i,
  input  logic               apd_i,
  input  logic               mpd_i,
  output logic [DATA_W-1:0]  sta_o,
  output logic [N_SDIN-1:0]  res_flag_o,
  output logic               gpi_flag_o
);
  logic [N_SDIN-1:0] res_q, res_clr;
  logic              rcs_q, gsc_q, rcs_clr, gsc_clr;
  logic              unused_wd;

  assign unused_wd = ^{wdata_i[31:30], wdata_i[28:16], wdata_i[14:12], wdata_i[9:1]};
  assign res_clr   = wr_i ? {wdata_i[29], wdata_i[11], wdata_i[10]} : '0;
  assign rcs_clr   = wr_i & wdata_i[15];
  assign gsc_clr   = wr_i & wdata_i[0];

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      rcs_q <= 1'b0;
      gsc_q <= 1'b0;
    end else begin
      res_q <= (res_q & ~res_clr) | resume_i;
      rcs_q <= (rcs_q & ~rcs_clr) | rdone_i;
      gsc_q <= (gsc_q & ~gsc_clr) | gpi_i;
    end
  end

  always_comb begin
    sta_o     = '0;
    sta_o[0]  = gsc_q;
    sta_o[1]  = chirq_i[0];
    sta_o[2]  = chirq_i[1];
    sta_o[5]  = chirq_i[2];
    sta_o[6]  = chirq_i[3];
    sta_o[7]  = chirq_i[4];
    sta_o[8]  = ready_i[0];
    sta_o[9]  = ready_i[1];
    sta_o[10] = res_q[0];
    sta_o[11] = res_q[1];
    sta_o[15] = rcs_q;
    sta_o[16] = apd_i;
    sta_o[17] = mpd_i;
    sta_o[20] = CAP_4CH;
    sta_o[21] = CAP_6CH;
    sta_o[28] = ready_i[2];
    sta_o[29] = res_q[2];
  end

  assign res_flag_o = res_q;
  assign gpi_flag_o = gsc_q;
endmodule

// File: rtl/alink_sem.sv
module alink_sem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic done_i,
  output logic sem_o
);
  logic sem_q;

  // release first, then a read claims the bit if it returned 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sem_q <= 1'b0;
    else if (rd_i)   sem_q <= sem_q ? !done_i : 1'b1;
    else if (done_i) sem_q <= 1'b0;
  end

  assign sem_o = sem_q;
endmodule

// File: rtl/alink_glb_ctrl.sv
module alink_glb_ctrl
  import alink_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 16,
  parameter bit          CAP_4CH     = 1'b1,
  parameter bit          CAP_6CH     = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [7:0]   reg_addr_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [31:0]  reg_wdata_i,
  output logic [31:0]  reg_rdata_o,
  input  logic [2:0]   codec_ready_i,
  input  logic [2:0]   resume_evt_i,
  input  logic [4:0]   chan_irq_i,
  input  logic         gpi_evt_i,
  input  logic         rd_done_i,
  input  logic         access_done_i,
  input  logic         audio_pd_i,
  input  logic         modem_pd_i,
  output logic         cold_rst_no,
  output logic         warm_rst_o,
  output logic         link_off_o,
  output logic [1:0]   chan_sel_o,
  output logic         wide_smp_o,
  output logic         irq_o
);
  logic [DATA_W-1:0] ctrl_word, sta_word;
  logic              wr_ctrl, wr_sta, rd_sem, sem_bit;
  logic              cold_rel, gpi_ie, gpi_flag;
  logic [N_SDIN-1:0] res_ie, res_flag;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == CTRL_OFF);
  assign wr_sta  = reg_wr_i && (reg_addr_i == STA_OFF);
  assign rd_sem  = reg_rd_i && (reg_addr_i == SEM_OFF);

  alink_ctrl_reg #(.WARM_CYCLES(WARM_CYCLES)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i       (wr_ctrl),
    .wdata_i    (reg_wdata_i),
    .ctrl_o     (ctrl_word),
    .cold_rel_o (cold_rel),
    .warm_o     (warm_rst_o),
    .link_off_o (link_off_o),
    .chan_o     (chan_sel_o),
    .wide_o     (wide_smp_o),
    .gpi_ie_o   (gpi_ie),
    .res_ie_o   (res_ie)
  );

  alink_sta_reg #(.CAP_4CH(CAP_4CH), .CAP_6CH(CAP_6CH)) u_sta (
    .clk_i, .rst_ni,
    .wr_i       (wr_sta),
    .wdata_i    (reg_wdata_i),
    .ready_i    (codec_ready_i),
    .resume_i   (resume_evt_i),
    .chirq_i    (chan_irq_i),
    .gpi_i      (gpi_evt_i),
    .rdone_i    (rd_done_i),
    .apd_i      (audio_pd_i),
    .mpd_i      (modem_pd_i),
    .sta_o      (sta_word),
    .res_flag_o (res_flag),
    .gpi_flag_o (gpi_flag)
  );

  alink_sem u_sem (
    .clk_i, .rst_ni,
    .rd_i   (rd_sem),
    .done_i (access_done_i),
    .sem_o  (sem_bit)
  );

  always_comb begin
    unique case (reg_addr_i)
      CTRL_OFF: reg_rdata_o = ctrl_word;
      STA_OFF:  reg_rdata_o = sta_word;
      SEM_OFF:  reg_rdata_o = {31'd0, sem_bit};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign cold_rst_no = cold_rel;
  assign irq_o = (|chan_irq_i) | (|(res_flag & res_ie)) | (gpi_flag & gpi_ie);
endmodule

// File: rtl/alink_glb_ctrl_chk.sv
module alink_glb_ctrl_chk #(
  parameter int unsigned WARM_CYCLES = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_sem,
  input logic       access_done_i,
  input logic       sem_bit,
  input logic [4:0] chan_irq_i,
  input logic       cold_rst_no,
  input logic       warm_rst_o,
  input logic [1:0] chan_sel_o,
  input logic       irq_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_cnt <= '0;
    else if (warm_rst_o) hi_cnt <= hi_cnt + 32'd1;
    else                 hi_cnt <= '0;
  end

  p_warm_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> (hi_cnt < WARM_CYCLES));

  p_warm_cold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_rst_no |-> !warm_rst_o);

  p_warm_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warm_rst_o) |-> $past(cold_rst_no));

  p_chan_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_sel_o != 2'd3);

  p_sem_claim_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sem && !sem_bit) |=> sem_bit);

  p_sem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_bit && !access_done_i) |=> sem_bit);

  p_sem_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sem_bit && !rd_sem) |=> !sem_bit);

  p_irq_chan_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_irq_i != 5'd0) |-> irq_o);
endmodule

bind alink_glb_ctrl alink_glb_ctrl_chk #(.WARM_CYCLES(WARM_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rd_sem        (rd_sem),
  .access_done_i (access_done_i),
  .sem_bit       (sem_bit),
  .chan_irq_i    (chan_irq_i),
  .cold_rst_no   (cold_rst_no),
  .warm_rst_o    (warm_rst_o),
  .chan_sel_o    (chan_sel_o),
  .irq_o         (irq_o)
);

// File: tb/sim_alink_glb_ctrl.sv
`timescale 1ns/1ps
module sim_alink_glb_ctrl;
  localparam int unsigned WARM = 16;
  localparam logic [7:0] A_CTRL = 8'h2C, A_STA = 8'h30, A_SEM = 8'h34;
  localparam logic [31:0] CAPS = 32'h0010_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wd = '0, rdata;
  logic [2:0]  rdy = '0, res = '0;
  logic [4:0]  chirq = '0;
  logic        gpi = 1'b0, rdone = 1'b0, adone = 1'b0, apd = 1'b0, mpd = 1'b0;
  logic        cold_n, warm, loff, wide, irq;
  logic [1:0]  chan;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  alink_glb_ctrl #(.WARM_CYCLES(WARM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .codec_ready_i(rdy), .resume_evt_i(res),
    .chan_irq_i(chirq), .gpi_evt_i(gpi), .rd_done_i(rdone), .access_done_i(adone),
    .audio_pd_i(apd), .modem_pd_i(mpd), .cold_rst_no(cold_n), .warm_rst_o(warm),
    .link_off_o(loff), .chan_sel_o(chan), .wide_smp_o(wide), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wd = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(A_CTRL, v); chk("R1 ctrl", v, 0);
    chk("R1 cold", cold_n, 0);
    chk("R1 warm", warm, 0);
    rd_reg(A_STA, v); chk("R1 sta", v, CAPS);
    rd_reg(A_SEM, v); chk("R1 sem", v, 0);
  endtask

  task automatic t_sem();
    logic [31:0] v;
    rd_reg(A_SEM, v); chk("R10 held", v, 1);
    wr_reg(A_SEM, 0);
    rd_reg(A_SEM, v); chk("R10 write ignored", v, 1);
    @(negedge clk); adone = 1'b1; @(negedge clk); adone = 1'b0;
    rd_reg(A_SEM, v); chk("R10 released", v, 0);
    rd_reg(A_SEM, v); chk("R10 reclaimed", v, 1);
    @(negedge clk); adone = 1'b1; @(negedge clk); adone = 1'b0;
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr_reg(A_CTRL, 32'h7B);
    rd_reg(A_CTRL, v); chk("R2 readback", v, 32'h7B);
    chk("R2 cold released", cold_n, 1);
    chk("R2 link off", loff, 1);
    wr_reg(A_CTRL, 32'h02);
    chk("R2 link on", loff, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr_reg(A_CTRL, 32'h0020_0002);
    chk("R3 six chan", chan, 2);
    wr_reg(A_CTRL, 32'h0030_0002);
    chk("R3 reserved ignored", chan, 2);
    rd_reg(A_CTRL, v); chk("R3 readback", v, 32'h0020_0002);
    wr_reg(A_CTRL, 32'h0050_0002);
    chk("R4 wide", wide, 1);
    chk("R3 four chan", chan, 1);
    wr_reg(A_CTRL, 32'h00C0_0002);
    rd_reg(A_CTRL, v); chk("R4 bit23 reads 0", v, 32'h0040_0002);
    wr_reg(A_CTRL, 32'h02);
    chk("R4 narrow", wide, 0);
  endtask

  task automatic t_warm();
    logic [31:0] v;
    int n;
    wr_reg(A_CTRL, 32'h06);
    chk("R5 warm start", warm, 1);
    n = 0;
    while (warm && n < 1000) begin n++; @(negedge clk); end
    chk("R5 warm length", n, WARM);
    rd_reg(A_CTRL, v); chk("R5 bit2 cleared", v, 32'h02);
  endtask

  task automatic t_warm_cold();
    wr_reg(A_CTRL, 32'h00);
    chk("R6 cold active", cold_n, 0);
    wr_reg(A_CTRL, 32'h04);
    chk("R6 warm ignored bit1=0", warm, 0);
    wr_reg(A_CTRL, 32'h06);
    chk("R6 warm ignored from cold", warm, 0);
    wr_reg(A_CTRL, 32'h06);
    chk("R6 warm after release", warm, 1);
    wr_reg(A_CTRL, 32'h00);
    chk("R6 warm cancelled", warm, 0);
    wr_reg(A_CTRL, 32'h02);
  endtask

  task automatic t_sta_ro();
    logic [31:0] v, e;
    rdy = 3'b101; chirq = 5'b10110; apd = 1'b1; mpd = 1'b0;
    e = CAPS | (32'h1 << 8) | (32'h1 << 28) | (32'h1 << 7) | (32'h1 << 5) | (32'h1 << 2) | (32'h1 << 16);
    rd_reg(A_STA, v); chk("R7 ro set A", v, e);
    wr_reg(A_STA, 32'hFFFF_FFFF);
    rd_reg(A_STA, v); chk("R7 write no effect", v, e);
    rdy = 3'b010; chirq = 5'b01001; apd = 1'b0; mpd = 1'b1;
    e = CAPS | (32'h1 << 9) | (32'h1 << 6) | (32'h1 << 1) | (32'h1 << 17);
    rd_reg(A_STA, v); chk("R7 ro set B", v, e);
    rdy = '0; chirq = '0; mpd = 1'b0;
  endtask

  task automatic t_w1c();
    logic [31:0] v, e;
    @(negedge clk); res = 3'b011; rdone = 1'b1; gpi = 1'b1;
    @(negedge clk); res = '0; rdone = 1'b0; gpi = 1'b0;
    e = CAPS | (32'h1 << 10) | (32'h1 << 11) | (32'h1 << 15) | 32'h1;
    rd_reg(A_STA, v); chk("R8 R9 set", v, e);
    wr_reg(A_STA, 32'h0);
    rd_reg(A_STA, v); chk("R8 write 0", v, e);
    wr_reg(A_STA, 32'h1 << 10);
    e = e & ~(32'h1 << 10);
    rd_reg(A_STA, v); chk("R8 clear one", v, e);
    wr_reg(A_STA, (32'h1 << 15) | 32'h1);
    e = CAPS | (32'h1 << 11);
    rd_reg(A_STA, v); chk("R9 cleared", v, e);
    @(negedge clk); res = 3'b100; @(negedge clk); res = '0;
    @(negedge clk); addr = A_STA; wd = 32'hFFFF_FFFF; wr = 1'b1; res = 3'b100;
    @(negedge clk); wr = 1'b0; res = '0;
    rd_reg(A_STA, v); chk("R8 set wins", v, CAPS | (32'h1 << 29));
    wr_reg(A_STA, 32'hFFFF_FFFF);
    rd_reg(A_STA, v); chk("R8 all cleared", v, CAPS);
  endtask

  task automatic t_irq();
    wr_reg(A_CTRL, 32'h02);
    @(negedge clk); res = 3'b001; @(negedge clk); res = '0;
    chk("R11 masked resume", irq, 0);
    wr_reg(A_CTRL, 32'h12);
    chk("R11 enabled resume", irq, 1);
    wr_reg(A_STA, 32'h1 << 10);
    chk("R11 resume cleared", irq, 0);
    @(negedge clk); gpi = 1'b1; @(negedge clk); gpi = 1'b0;
    chk("R11 masked gpi", irq, 0);
    wr_reg(A_CTRL, 32'h03);
    chk("R11 enabled gpi", irq, 1);
    wr_reg(A_STA, 32'h1);
    chk("R11 gpi cleared", irq, 0);
    chirq = 5'b00100; #1;
    chk("R11 channel irq", irq, 1);
    chirq = '0; #1;
    chk("R11 idle", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sem();
    t_ctrl();
    t_fields();
    t_warm();
    t_warm_cold();
    t_sta_ro();
    t_w1c();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule